// File: doc/BRIEF.md
# Flip-Flop Multiport Register Memory

A parameterised storage array of SIZE words of WIDTH bits, with ABITS address bits, built only from word-wide registers, per-word write decode and 2:1 read multiplexers. It has WR_PORTS write ports and RD_PORTS read ports. Every port's address, data and enable sit in flat vectors, with port i at slice i (for example, the address of port i is bits `[i*ABITS +: ABITS]`).

All write ports share one write clock and one edge polarity. When more than one write port hits the same word on the same edge, the port with the highest index wins. Each read port is set by parameter to be either combinational or address-latched. An address-latched port stores its address on its own read clock, and its data then follows the current contents of that stored location. A write to the stored location therefore shows on the output right after the write edge. Word contents have no reset. Only the latched read addresses are cleared by the active-low asynchronous reset.

Top module: `ff_regfile_mem`

## Requirements
- R1: Word contents change only on the active edge of `wr_clk_i` (rising when WR_CLK_POL=1). Between write edges, a read of an unchanged address returns unchanged data.
- R2: On a write edge, a word takes port p's data only when `wr_en_i[p]` is 1 and port p's address equals the word's index. All other words keep their value.
- R3: When several enabled write ports address the same word on one edge, the data of the highest-numbered port is stored.
- R4: A write port with `wr_en_i[p]`=0 changes no word, whatever its address and data.
- R5: A read port whose bit in RD_CLK_EN is 0 returns the word at its address combinationally, in the same cycle the address is applied.
- R6: A read port whose bit in RD_CLK_EN is 1 captures its address on the active edge of `rd_clk_i[i]` (rising when its RD_CLK_POL bit is 1). Its data is then the word at the captured address, and an address change before that edge does not alter the output.
- R7: On an address-latched read port, a write to the captured address appears on the output right after the write edge, with no further read clock edge.
- R8: A write to an address at or above SIZE changes no word. A read from such an address returns zero.
- R9: While `rst_ni` is 0, every latched read address is held at 0, so the port returns word 0. Word contents are not affected by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Shared write clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the latched read addresses |
| wr_en_i | input | WR_PORTS | Write enable, one bit per port |
| wr_addr_i | input | WR_PORTS*ABITS | Packed write addresses |
| wr_data_i | input | WR_PORTS*WIDTH | Packed write data |
| rd_clk_i | input | RD_PORTS | Read clock per port (used by latched ports only) |
| rd_addr_i | input | RD_PORTS*ABITS | Packed read addresses |
| rd_data_o | output | RD_PORTS*WIDTH | Packed read data |

## Verification
The bound checker checks the following on every write edge, as seen through combinational read port 0:
- A read from an address at or above SIZE returns zero.
- A cycle with no write enabled leaves the data at a held address unchanged.
- The highest-numbered write port always lands at its address.

On every read clock edge, it also checks that a latched port agrees with port 0 whenever port 0 points at the address captured on the previous edge.

Other behaviour needs the bench's directed scenarios, which compare against a behavioural model:
- partial collisions between lower-numbered ports;
- writes that are enabled but land out of range;
- the pre-edge hold of a latched address;
- write visibility through a held latched address;
- the retention of contents across a mid-run reset.

// File: rtl/ff_regfile_pkg.sv
package ff_regfile_pkg;
  typedef enum logic {
    RD_ASYNC   = 1'b0,
    RD_LATCHED = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/ff_regfile_store.sv
module ff_regfile_store #(
  parameter int   SIZE       = 12,
  parameter int   WIDTH      = 8,
  parameter int   ABITS      = 4,
  parameter int   WR_PORTS   = 3,
  parameter logic WR_CLK_POL = 1'b1
) (
  input  logic                      wr_clk_i,
  input  logic [WR_PORTS-1:0]       wr_en_i,
  input  logic [WR_PORTS*ABITS-1:0] wr_addr_i,
  input  logic [WR_PORTS*WIDTH-1:0] wr_data_i,
  output logic [SIZE*WIDTH-1:0]     words_o
);
  for (genvar w = 0; w < SIZE; w++) begin : g_word
    logic [WIDTH-1:0] q, d;

    // select chain in ascending port order: later ports override earlier ones
    always_comb begin
      d = q;
      for (int p = 0; p < WR_PORTS; p++) begin
        if (wr_en_i[p] && (wr_addr_i[p*ABITS +: ABITS] == ABITS'(w)))
          d = wr_data_i[p*WIDTH +: WIDTH];
      end
    end

    if (WR_CLK_POL) begin : g_pos
      always_ff @(posedge wr_clk_i) q <= d;
    end else begin : g_neg
      always_ff @(negedge wr_clk_i) q <= d;
    end

    assign words_o[w*WIDTH +: WIDTH] = q;
  end
endmodule

// File: rtl/ff_regfile_rdmux.sv
module ff_regfile_rdmux #(
  parameter int SIZE  = 12,
  parameter int WIDTH = 8,
  parameter int ABITS = 4
) (
  input  logic [SIZE*WIDTH-1:0] words_i,
  input  logic [ABITS-1:0]      addr_i,
  output logic [WIDTH-1:0]      data_o
);
  localparam int LEAVES = 1 << ABITS;

  // heap-indexed tree: node 1 is the root, leaves start at LEAVES
  logic [WIDTH-1:0] node [1:2*LEAVES-1];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < SIZE) begin : g_word
      assign node[LEAVES+j] = words_i[j*WIDTH +: WIDTH];
    end else begin : g_zero
      assign node[LEAVES+j] = '0;
    end
  end

  // depth d decodes address bit ABITS-1-d, so the MSB selects at the root
  for (genvar d = 0; d < ABITS; d++) begin : g_lvl
    for (genvar k = 0; k < (1 << d); k++) begin : g_node
      localparam int N = (1 << d) + k;
      assign node[N] = addr_i[ABITS-1-d] ? node[2*N+1] : node[2*N];
    end
  end

  assign data_o = node[1];
endmodule

// File: rtl/ff_regfile_rdport.sv
module ff_regfile_rdport
  import ff_regfile_pkg::*;
#(
  parameter int       SIZE    = 12,
  parameter int       WIDTH   = 8,
  parameter int       ABITS   = 4,
  parameter rd_mode_e MODE    = RD_ASYNC,
  parameter logic     CLK_POL = 1'b1
) (
  input  logic                  rd_clk_i,
  input  logic                  rst_ni,
  input  logic [SIZE*WIDTH-1:0] words_i,
  input  logic [ABITS-1:0]      rd_addr_i,
  output logic [WIDTH-1:0]      rd_data_o
);
  logic [ABITS-1:0] sel_addr;

  if (MODE == RD_LATCHED) begin : g_latched
    logic [ABITS-1:0] addr_q;
    if (CLK_POL) begin : g_pos
      always_ff @(posedge rd_clk_i or negedge rst_ni)
        if (!rst_ni) addr_q <= '0;
        else         addr_q <= rd_addr_i;
    end else begin : g_neg
      always_ff @(negedge rd_clk_i or negedge rst_ni)
        if (!rst_ni) addr_q <= '0;
        else         addr_q <= rd_addr_i;
    end
    assign sel_addr = addr_q;
  end else begin : g_async
    logic unused_ctl;
    assign unused_ctl = rd_clk_i ^ rst_ni;
    assign sel_addr   = rd_addr_i;
  end

  ff_regfile_rdmux #(
    .SIZE (SIZE),
    .WIDTH(WIDTH),
    .ABITS(ABITS)
  ) u_mux (
    .words_i(words_i),
    .addr_i (sel_addr),
    .data_o (rd_data_o)
  );
endmodule

// File: rtl/ff_regfile_mem.sv
module ff_regfile_mem
  import ff_regfile_pkg::*;
#(
  parameter int                  SIZE       = 12,
  parameter int                  WIDTH      = 8,
  parameter int                  ABITS      = 4,
  parameter int                  WR_PORTS   = 3,
  parameter int                  RD_PORTS   = 3,
  parameter logic                WR_CLK_POL = 1'b1,
  parameter logic [RD_PORTS-1:0] RD_CLK_EN  = 3'b010,
  parameter logic [RD_PORTS-1:0] RD_CLK_POL = 3'b111
) (
  input  logic                      wr_clk_i,
  input  logic                      rst_ni,
  input  logic [WR_PORTS-1:0]       wr_en_i,
  input  logic [WR_PORTS*ABITS-1:0] wr_addr_i,
  input  logic [WR_PORTS*WIDTH-1:0] wr_data_i,
  input  logic [RD_PORTS-1:0]       rd_clk_i,
  input  logic [RD_PORTS*ABITS-1:0] rd_addr_i,
  output logic [RD_PORTS*WIDTH-1:0] rd_data_o
);
  localparam int WORD_BITS = SIZE * WIDTH;

  logic [WORD_BITS-1:0] words;

  ff_regfile_store #(
    .SIZE      (SIZE),
    .WIDTH     (WIDTH),
    .ABITS     (ABITS),
    .WR_PORTS  (WR_PORTS),
    .WR_CLK_POL(WR_CLK_POL)
  ) u_store (
    .wr_clk_i (wr_clk_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .words_o  (words)
  );

  for (genvar i = 0; i < RD_PORTS; i++) begin : g_rd
    ff_regfile_rdport #(
      .SIZE   (SIZE),
      .WIDTH  (WIDTH),
      .ABITS  (ABITS),
      .MODE   (rd_mode_e'(RD_CLK_EN[i])),
      .CLK_POL(RD_CLK_POL[i])
    ) u_port (
      .rd_clk_i (rd_clk_i[i]),
      .rst_ni   (rst_ni),
      .words_i  (words),
      .rd_addr_i(rd_addr_i[i*ABITS +: ABITS]),
      .rd_data_o(rd_data_o[i*WIDTH +: WIDTH])
    );
  end
endmodule

// File: rtl/ff_regfile_chk.sv
module ff_regfile_chk #(
  parameter int                  SIZE       = 12,
  parameter int                  WIDTH      = 8,
  parameter int                  ABITS      = 4,
  parameter int                  WR_PORTS   = 3,
  parameter int                  RD_PORTS   = 3,
  parameter logic                WR_CLK_POL = 1'b1,
  parameter logic [RD_PORTS-1:0] RD_CLK_EN  = 3'b010,
  parameter logic [RD_PORTS-1:0] RD_CLK_POL = 3'b111
) (
  input logic                      wr_clk_i,
  input logic                      rst_ni,
  input logic [WR_PORTS-1:0]       wr_en_i,
  input logic [WR_PORTS*ABITS-1:0] wr_addr_i,
  input logic [WR_PORTS*WIDTH-1:0] wr_data_i,
  input logic [RD_PORTS-1:0]       rd_clk_i,
  input logic [RD_PORTS*ABITS-1:0] rd_addr_i,
  input logic [RD_PORTS*WIDTH-1:0] rd_data_o
);
  logic [ABITS-1:0] ra0;
  logic [WIDTH-1:0] rd0;
  logic             top_hit;

  assign ra0 = rd_addr_i[0 +: ABITS];
  assign rd0 = rd_data_o[0 +: WIDTH];
  assign top_hit = wr_en_i[WR_PORTS-1]
                && (wr_addr_i[(WR_PORTS-1)*ABITS +: ABITS] == ra0)
                && (int'(ra0) < SIZE);

  if (WR_CLK_POL && !RD_CLK_EN[0]) begin : g_wr
    // R8: out-of-range read returns zero
    assert_oob_zero_R8: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
      (int'(ra0) >= SIZE) |-> (rd0 == '0));

    // R4: with every enable low, a held address keeps its data
    assert_idle_hold_R4: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
      ($past(wr_en_i == '0) && $stable(ra0)) |-> $stable(rd0));

    // R3: the highest-numbered port always lands
    assert_top_wins_R3: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
      ($past(top_hit) && $stable(ra0)) |->
        (rd0 == $past(wr_data_i[(WR_PORTS-1)*WIDTH +: WIDTH])));
  end

  for (genvar s = 1; s < RD_PORTS; s++) begin : g_lat
    if (RD_CLK_EN[s] && RD_CLK_POL[s] && !RD_CLK_EN[0]) begin : g_on
      logic armed;
      always_ff @(posedge rd_clk_i[s] or negedge rst_ni)
        if (!rst_ni) armed <= 1'b0;
        else         armed <= 1'b1;

      // R6: latched port reads the address captured on the previous edge
      assert_latched_addr_R6: assert property (@(posedge rd_clk_i[s]) disable iff (!rst_ni)
        (armed && (ra0 == $past(rd_addr_i[s*ABITS +: ABITS]))) |->
          (rd_data_o[s*WIDTH +: WIDTH] == rd0));
    end
  end
endmodule

bind ff_regfile_mem ff_regfile_chk #(
  .SIZE      (SIZE),
  .WIDTH     (WIDTH),
  .ABITS     (ABITS),
  .WR_PORTS  (WR_PORTS),
  .RD_PORTS  (RD_PORTS),
  .WR_CLK_POL(WR_CLK_POL),
  .RD_CLK_EN (RD_CLK_EN),
  .RD_CLK_POL(RD_CLK_POL)
) u_chk (
  .wr_clk_i (wr_clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .rd_clk_i (rd_clk_i),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o)
);

// File: tb/ff_regfile_mem_tb.sv
`timescale 1ns/1ps
module ff_regfile_mem_tb;
  localparam int SIZE = 12, WIDTH = 8, ABITS = 4, WP = 3, RP = 3;
  localparam int LAT = 1; // port 1 is address-latched, ports 0 and 2 combinational

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic [WP-1:0]       wr_en = '0;
  logic [WP*ABITS-1:0] wr_addr = '0;
  logic [WP*WIDTH-1:0] wr_data = '0;
  logic [RP*ABITS-1:0] rd_addr = '0;
  logic [RP*WIDTH-1:0] rd_data;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [WIDTH-1:0] mem [16];
  bit               vld [16];
  int               lat_addr = 0;

  always #10 clk = ~clk;

  ff_regfile_mem u_dut (
    .wr_clk_i (clk),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_clk_i ({RP{clk}}),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  task automatic chk_addr(string tag, int port, int a);
    logic [WIDTH-1:0] exp, act;
    act = rd_data[port*WIDTH +: WIDTH];
    if (a >= SIZE) exp = '0;
    else if (!vld[a]) return;
    else exp = mem[a];
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s port %0d addr %0d: got %h expected %h", tag, port, a, act, exp);
    end
  endtask

  task automatic chk_ports(string tag);
    chk_addr(tag, 0, int'(rd_addr[0 +: ABITS]));
    chk_addr(tag, LAT, lat_addr);
    chk_addr(tag, 2, int'(rd_addr[2*ABITS +: ABITS]));
  endtask

  // called just after a falling edge with inputs already driven
  task automatic step(string tag);
    #2 chk_ports(tag); // R5 same-cycle comb read; R6 latched port ignores new address before edge
    @(posedge clk);
    for (int p = 0; p < WP; p++) begin
      int a;
      a = int'(wr_addr[p*ABITS +: ABITS]);
      if (wr_en[p] && a < SIZE) begin
        mem[a] = wr_data[p*WIDTH +: WIDTH];
        vld[a] = 1'b1;
      end
    end
    lat_addr = int'(rd_addr[LAT*ABITS +: ABITS]);
    #5 chk_ports(tag);
    @(negedge clk);
  endtask

  task automatic set_wr(int p, logic en, int a, logic [WIDTH-1:0] d);
    wr_en[p] = en;
    wr_addr[p*ABITS +: ABITS] = ABITS'(a);
    wr_data[p*WIDTH +: WIDTH] = d;
  endtask

  task automatic set_rd(int p, int a);
    rd_addr[p*ABITS +: ABITS] = ABITS'(a);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = '0; vld[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: fill every word, spreading across ports
    for (int w = 0; w < SIZE; w++) begin
      wr_en = '0;
      set_wr(w % WP, 1'b1, w, WIDTH'(8'h30 + w));
      set_rd(0, w); set_rd(LAT, (w + 3) % SIZE); set_rd(2, (w + 7) % 16);
      step("R2");
    end
    wr_en = '0;

    // R5: combinational reads sweep all addresses, no writes
    for (int a = 0; a < 16; a++) begin
      set_rd(0, a); set_rd(2, 15 - a); set_rd(LAT, a);
      step("R5");
    end

    // R3: all three ports on one word, then ports 0 and 1 only
    set_wr(0, 1, 4, 8'h11); set_wr(1, 1, 4, 8'h22); set_wr(2, 1, 4, 8'h33);
    set_rd(0, 4); set_rd(LAT, 4); set_rd(2, 4);
    step("R3");
    set_wr(0, 1, 6, 8'h44); set_wr(1, 1, 6, 8'h55); set_wr(2, 1, 9, 8'h66);
    set_rd(0, 6); set_rd(2, 9);
    step("R3");
    set_rd(0, 6); set_rd(2, 9); wr_en = '0;
    step("R3");

    // R4: enables low with live address/data change nothing
    set_wr(0, 0, 2, 8'hDE); set_wr(1, 0, 2, 8'hAD); set_wr(2, 0, 3, 8'hBE);
    set_rd(0, 2); set_rd(LAT, 3); set_rd(2, 3);
    step("R4"); step("R4");

    // R8: out-of-range writes, out-of-range reads
    set_wr(0, 1, 12, 8'hF0); set_wr(1, 1, 13, 8'hF1); set_wr(2, 1, 15, 8'hF2);
    set_rd(0, 12); set_rd(LAT, 15); set_rd(2, 0);
    step("R8"); wr_en = '0; step("R8");
    set_rd(0, 11); set_rd(2, 13); step("R8");

    // R6: latch address 7, then move the port address before next edge
    set_rd(LAT, 7); step("R6");
    set_rd(LAT, 1); step("R6");

    // R7: hold latched address 5, write it, visible right after write edge
    set_rd(LAT, 5); set_rd(0, 0); set_rd(2, 1); step("R7");
    set_wr(0, 1, 5, 8'hA5); step("R7");
    set_wr(0, 0, 5, 8'h00); set_wr(2, 1, 5, 8'h5A); step("R7");
    wr_en = '0;

    // R9: mid-run reset clears latched address, contents remain
    set_rd(LAT, 9); step("R9");
    #1 rst_ni = 1'b0; lat_addr = 0;
    #2 chk_ports("R9");
    #2 rst_ni = 1'b1;
    step("R9");

    // R1: random traffic on every port
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < WP; p++)
        set_wr(p, logic'($urandom_range(0, 1)), $urandom_range(0, 15), WIDTH'($urandom));
      for (int p = 0; p < RP; p++) set_rd(p, $urandom_range(0, 15));
      step("R1");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule